// File: doc/BRIEF.md
# Programmable Tone and Ring Generator

This block synthesises call-progress, ring and dual-frequency signalling tones as a stream of signed 16-bit samples. Each sample is produced on a one-cycle sample strobe, normally pulsed at 8 kHz. Two independent tone channels each run a phase accumulator. The per-sample increment of a channel is its 8-bit frequency code scaled by a range select. This gives steps of about 3.9 Hz, 7.8 Hz or 15.6 Hz, and upper limits near 996 Hz, 1992 Hz and 3984 Hz respectively.

Either channel can be shaped as a sampled sine or as a square wave. The first channel can be played on its own, or both channels can be mixed at half amplitude each to form a dual-tone signal. A final attenuator scales the result in 3 dB steps over a 27 dB span. The block is driven by a controller that holds the configuration inputs steady and pulses the sample strobe. The downstream converter takes each sample on the cycle its valid flag is high.

Top module: `tonegen_core`

## Requirements
- R1: While `rst_n` is low (sampled synchronously) or `enable` is low, `tone_out` is 0, `tone_valid` is 0 and both phase accumulators return to 0. A strobe in the same cycle as `enable` low is dropped, and the first strobe after re-enable plays phase 0.
- R2: A strobe seen with `enable` high makes `tone_valid` high for exactly the next cycle. `tone_out` then holds its value until the next strobe. The sample produced by a strobe is computed from the phases as they stood before that strobe.
- R3: Each strobe advances each channel's 11-bit phase by its code shifted left by the range: `range_sel` 0 gives ×1 (~3.9 Hz step), 1 gives ×2 (~7.8 Hz), and 2 or 3 give ×4 (~15.6 Hz). The phase wraps modulo 2048.
- R4: In sine mode (`wave_square`=0) the 8-bit index is phase bits [10:3]. Its bits [7:6] select the quadrant and bits [5:0] give j. Define q(i) = floor(32767·i·(128−i)/4096). Quadrants 0 to 3 give q(j), q(64−j), −q(j) and −q(64−j).
- R5: In square mode (`wave_square`=1) a channel gives +32767 when phase bit 10 is 0 and −32767 when it is 1.
- R6: With `dual_tone`=0 the mix is channel A alone. With `dual_tone`=1 it is (A>>>1)+(B>>>1), where >>> is an arithmetic shift.
- R7: Attenuation codes 0 to 9 select the gain 32768, 23198, 16423, 11627, 8231, 5827, 4125, 2920, 2068 or 1464 (Q15, 3 dB per step). Codes 10 to 15 act as code 9.
- R8: `tone_out` = floor(mix·gain / 32768), which is an arithmetic right shift of the exact product by 15.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| enable | input | 1 | Run the generator; low clears outputs and phases |
| sample_tick | input | 1 | One-cycle sample strobe |
| freq_a | input | 8 | Frequency code, channel A |
| freq_b | input | 8 | Frequency code, channel B |
| range_sel | input | 2 | Step range: 0 ×1, 1 ×2, 2/3 ×4 |
| wave_square | input | 1 | 0 sine, 1 square |
| dual_tone | input | 1 | 1 mixes both channels at half amplitude |
| atten_code | input | 4 | Attenuation, 3 dB per step, clamped at 9 |
| tone_out | output | 16 | Signed output sample |
| tone_valid | output | 1 | High for one cycle after each accepted strobe |

## Verification
Two events can land in the same cycle: a sample strobe and the drop of `enable`. The bench provokes this by raising the strobe and lowering `enable` on one edge while a tone is running. The next cycle must show a zero sample with no valid flag. The following re-enabled strobe must then play phase 0, which shows that the strobe neither produced a sample nor advanced the accumulators. The rest of the checking sweeps every range, waveform, mix mode and attenuation code, a full sine period at the smallest step, and all 256 codes. Each sample is compared against values computed in the bench.

// File: rtl/tonegen_pkg.sv
// Package: shared constants and constant functions for the tone generator.
// Assumes PHASE_W >= FREQ_W + 2 so that the largest shifted code fits.
package tonegen_pkg;

    localparam int FREQ_W     = 8;
    localparam int PHASE_W    = 11;
    localparam int SAMPLE_W   = 16;
    localparam int LUT_ADDR_W = 6;
    localparam int IDX_W      = LUT_ADDR_W + 2;
    localparam int QTR        = 1 << LUT_ADDR_W;
    localparam int ATT_W      = 4;
    localparam int GAIN_W     = 16;
    localparam int GAIN_FRAC  = 15;
    localparam int AMP        = (1 << (SAMPLE_W - 1)) - 1;

    // Range select encoding.
    typedef enum logic [1:0] {
        RNG_X1 = 2'd0,
        RNG_X2 = 2'd1,
        RNG_X4 = 2'd2,
        RNG_X4B = 2'd3
    } range_e;

    // Parabolic quarter-wave point: amp*i*(2q-i)/(q*q), i in 0..q.
    function automatic int quarter_sine(input int i, input int q, input int amp);
        longint num;
        num = longint'(amp) * longint'(i) * longint'(2 * q - i);
        return int'(num / (longint'(q) * longint'(q)));
    endfunction

    // Q15 gain for a 3 dB-per-step attenuation code; codes above 9 clamp.
    function automatic logic [GAIN_W-1:0] gain_q15(input logic [ATT_W-1:0] code);
        logic [GAIN_W-1:0] g;
        case (code)
            4'd0:    g = 16'd32768;
            4'd1:    g = 16'd23198;
            4'd2:    g = 16'd16423;
            4'd3:    g = 16'd11627;
            4'd4:    g = 16'd8231;
            4'd5:    g = 16'd5827;
            4'd6:    g = 16'd4125;
            4'd7:    g = 16'd2920;
            4'd8:    g = 16'd2068;
            default: g = 16'd1464;
        endcase
        return g;
    endfunction

endpackage

// File: rtl/tg_phase_acc.sv
// Module: tg_phase_acc
// One tone channel's phase accumulator. On each step the phase advances by
// the frequency code shifted left by 0, 1 or 2 according to the range.
// Assumes PHASE_W >= FREQ_W + 2. Exposes only the top IDX_W phase bits.
module tg_phase_acc #(
    parameter int FREQ_W  = tonegen_pkg::FREQ_W,
    parameter int PHASE_W = tonegen_pkg::PHASE_W,
    parameter int IDX_W   = tonegen_pkg::IDX_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               clear,
    input  logic               step,
    input  logic [FREQ_W-1:0]  freq_code,
    input  logic [1:0]         range_sel,
    output logic [IDX_W-1:0]   phase_idx
);
    import tonegen_pkg::*;

    logic [PHASE_W-1:0] phase_q;
    logic [PHASE_W-1:0] incr;

    // Purpose: scale the frequency code into a phase increment.
    always_comb begin
        case (range_e'(range_sel))
            RNG_X1:  incr = PHASE_W'(freq_code);
            RNG_X2:  incr = PHASE_W'(freq_code) << 1;
            default: incr = PHASE_W'(freq_code) << 2;
        endcase
    end

    // Purpose: hold or advance the phase; reset or clear returns it to zero.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            phase_q <= '0;
        end else if (step) begin
            phase_q <= phase_q + incr;
        end
    end

    assign phase_idx = phase_q[PHASE_W-1 -: IDX_W];

endmodule

// File: rtl/tg_waveform.sv
// Module: tg_waveform
// Turns a phase index into a signed sample: a quarter-wave table with
// quadrant folding for sine, or the phase sign for square.
// Assumes the table is filled at elaboration from a constant function.
module tg_waveform #(
    parameter int LUT_ADDR_W = tonegen_pkg::LUT_ADDR_W,
    parameter int SAMPLE_W   = tonegen_pkg::SAMPLE_W
) (
    input  logic [LUT_ADDR_W+1:0]       phase_idx,
    input  logic                        square_sel,
    output logic signed [SAMPLE_W-1:0]  wave
);
    import tonegen_pkg::*;

    localparam int Q   = 1 << LUT_ADDR_W;
    localparam int PK  = (1 << (SAMPLE_W - 1)) - 1;

    logic [SAMPLE_W-1:0]   lut [0:Q];
    logic [1:0]            quad;
    logic [LUT_ADDR_W-1:0] j;
    logic [LUT_ADDR_W:0]   addr;
    logic signed [SAMPLE_W-1:0] mag;

    // Quarter-wave table built from the parabolic sine approximation.
    for (genvar g = 0; g <= Q; g++) begin : g_lut
        assign lut[g] = SAMPLE_W'(quarter_sine(g, Q, PK));
    end

    // Purpose: fold the phase into the quarter table and pick the waveform.
    always_comb begin
        quad = phase_idx[LUT_ADDR_W+1:LUT_ADDR_W];
        j    = phase_idx[LUT_ADDR_W-1:0];
        addr = quad[0] ? ((LUT_ADDR_W+1)'(Q) - {1'b0, j}) : {1'b0, j};
        mag  = signed'(lut[addr]);
        if (square_sel) begin
            wave = quad[1] ? -(SAMPLE_W)'(PK) : (SAMPLE_W)'(PK);
        end else begin
            wave = quad[1] ? -mag : mag;
        end
    end

endmodule

// File: rtl/tg_mix_atten.sv
// Module: tg_mix_atten
// Mixes the two channels (A alone, or both halved and summed) and scales
// the mix by a Q15 gain picked by the attenuation code.
// Assumes halved inputs cannot overflow the sum; the product is floored.
module tg_mix_atten #(
    parameter int SAMPLE_W  = tonegen_pkg::SAMPLE_W,
    parameter int ATT_W     = tonegen_pkg::ATT_W,
    parameter int GAIN_W    = tonegen_pkg::GAIN_W,
    parameter int GAIN_FRAC = tonegen_pkg::GAIN_FRAC
) (
    input  logic signed [SAMPLE_W-1:0] tone_a,
    input  logic signed [SAMPLE_W-1:0] tone_b,
    input  logic                       dual,
    input  logic [ATT_W-1:0]           atten,
    output logic signed [SAMPLE_W-1:0] scaled
);
    import tonegen_pkg::*;

    localparam int PROD_W = SAMPLE_W + GAIN_W + 2;

    logic signed [SAMPLE_W-1:0] mix;
    logic signed [PROD_W-1:0]   mix_ext;
    logic signed [PROD_W-1:0]   gain_ext;
    logic signed [PROD_W-1:0]   prod;

    // Purpose: select single or halved dual-tone mix.
    always_comb begin
        if (dual) begin
            mix = (tone_a >>> 1) + (tone_b >>> 1);
        end else begin
            mix = tone_a;
        end
    end

    // Purpose: apply the attenuation gain with a floored Q15 product.
    always_comb begin
        mix_ext  = PROD_W'(mix);
        gain_ext = signed'({{(PROD_W-GAIN_W){1'b0}}, gain_q15(atten)});
        prod     = mix_ext * gain_ext;
        scaled   = SAMPLE_W'(prod >>> GAIN_FRAC);
    end

endmodule

// File: rtl/tonegen_core.sv
// Module: tonegen_core (top)
// Two-channel tone and ring generator. On each accepted sample strobe the
// output register takes the attenuated mix of the current phases, and the
// accumulators advance. Assumes config inputs are steady around a strobe.
module tonegen_core #(
    parameter int FREQ_W   = tonegen_pkg::FREQ_W,
    parameter int SAMPLE_W = tonegen_pkg::SAMPLE_W,
    parameter int ATT_W    = tonegen_pkg::ATT_W
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       enable,
    input  logic                       sample_tick,
    input  logic [FREQ_W-1:0]          freq_a,
    input  logic [FREQ_W-1:0]          freq_b,
    input  logic [1:0]                 range_sel,
    input  logic                       wave_square,
    input  logic                       dual_tone,
    input  logic [ATT_W-1:0]           atten_code,
    output logic signed [SAMPLE_W-1:0] tone_out,
    output logic                       tone_valid
);
    import tonegen_pkg::*;

    localparam int N_TONES = 2;

    logic                       step;
    logic [FREQ_W-1:0]          codes  [N_TONES];
    logic [IDX_W-1:0]           idx    [N_TONES];
    logic signed [SAMPLE_W-1:0] waves  [N_TONES];
    logic signed [SAMPLE_W-1:0] mixed;

    assign step     = enable && sample_tick;
    assign codes[0] = freq_a;
    assign codes[1] = freq_b;

    // One accumulator and waveform shaper per channel.
    for (genvar t = 0; t < N_TONES; t++) begin : g_tone
        tg_phase_acc #(
            .FREQ_W  (FREQ_W),
            .PHASE_W (PHASE_W),
            .IDX_W   (IDX_W)
        ) u_acc (
            .clk       (clk),
            .rst_n     (rst_n),
            .clear     (!enable),
            .step      (step),
            .freq_code (codes[t]),
            .range_sel (range_sel),
            .phase_idx (idx[t])
        );

        tg_waveform #(
            .LUT_ADDR_W (LUT_ADDR_W),
            .SAMPLE_W   (SAMPLE_W)
        ) u_wave (
            .phase_idx  (idx[t]),
            .square_sel (wave_square),
            .wave       (waves[t])
        );
    end

    tg_mix_atten #(
        .SAMPLE_W  (SAMPLE_W),
        .ATT_W     (ATT_W),
        .GAIN_W    (GAIN_W),
        .GAIN_FRAC (GAIN_FRAC)
    ) u_mix (
        .tone_a (waves[0]),
        .tone_b (waves[1]),
        .dual   (dual_tone),
        .atten  (atten_code),
        .scaled (mixed)
    );

    // Purpose: register one sample per accepted strobe; disable clears.
    always_ff @(posedge clk) begin
        if (!rst_n || !enable) begin
            tone_out   <= '0;
            tone_valid <= 1'b0;
        end else begin
            tone_valid <= sample_tick;
            if (sample_tick) begin
                tone_out <= mixed;
            end
        end
    end

endmodule

// File: rtl/tonegen_core_checker.sv
// Module: tonegen_core_checker
// Port-level timing and range properties of the tone generator, bound to
// the top module.
module tonegen_core_checker (
    input logic               clk,
    input logic               rst_n,
    input logic               enable,
    input logic               sample_tick,
    input logic               wave_square,
    input logic               dual_tone,
    input logic [3:0]         atten_code,
    input logic signed [15:0] tone_out,
    input logic               tone_valid
);
    AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> (tone_out == 16'sd0 && !tone_valid)); // R1
    AST_VALID_AFTER_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && sample_tick) |=> tone_valid); // R2
    AST_NO_VALID_WITHOUT_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        !(enable && sample_tick) |=> !tone_valid); // R2
    AST_HOLD_BETWEEN_TICKS: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && !sample_tick && $past(enable)) |=> $stable(tone_out)); // R2
    AST_SQUARE_LEVELS: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && sample_tick && wave_square && !dual_tone && atten_code == 4'd0)
        |=> (tone_out == 16'sd32767 || tone_out == -16'sd32767)); // R5
    AST_ATTEN_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && sample_tick && atten_code != 4'd0)
        |=> (tone_out <= 16'sd23198 && tone_out >= -16'sd23198)); // R7
endmodule

bind tonegen_core tonegen_core_checker u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .enable      (enable),
    .sample_tick (sample_tick),
    .wave_square (wave_square),
    .dual_tone   (dual_tone),
    .atten_code  (atten_code),
    .tone_out    (tone_out),
    .tone_valid  (tone_valid)
);

// File: tb/tonegen_core_bench.sv
// Bench: sweeps ranges, waveforms, mix modes, attenuation codes and all
// frequency codes; expected samples are computed arithmetically here.
module tonegen_core_bench;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              enable = 1'b0;
    logic              sample_tick = 1'b0;
    logic [7:0]        freq_a = '0;
    logic [7:0]        freq_b = '0;
    logic [1:0]        range_sel = '0;
    logic              wave_square = 1'b0;
    logic              dual_tone = 1'b0;
    logic [3:0]        atten_code = '0;
    logic signed [15:0] tone_out;
    logic              tone_valid;

    int errors = 0;
    int checks = 0;
    int ph_a = 0;
    int ph_b = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    tonegen_core u_tonegen_core (
        .clk         (clk),
        .rst_n       (rst_n),
        .enable      (enable),
        .sample_tick (sample_tick),
        .freq_a      (freq_a),
        .freq_b      (freq_b),
        .range_sel   (range_sel),
        .wave_square (wave_square),
        .dual_tone   (dual_tone),
        .atten_code  (atten_code),
        .tone_out    (tone_out),
        .tone_valid  (tone_valid)
    );

    function automatic int q_pt(input int i);
        return (32767 * i * (128 - i)) / 4096;
    endfunction

    // R4 / R5 waveform of one channel at an 11-bit phase.
    function automatic int wave_of(input int ph, input bit sq);
        int p8, quad, j, mag;
        if (sq) return (((ph >> 10) & 1) == 0) ? 32767 : -32767;
        p8   = (ph >> 3) & 255;
        quad = p8 >> 6;
        j    = p8 & 63;
        mag  = ((quad & 1) != 0) ? q_pt(64 - j) : q_pt(j);
        return ((quad & 2) != 0) ? -mag : mag;
    endfunction

    // R7 gain table with clamp.
    function automatic int gain_of(input int code);
        int g [10] = '{32768, 23198, 16423, 11627, 8231, 5827, 4125, 2920, 2068, 1464};
        return g[(code > 9) ? 9 : code];
    endfunction

    // R6 / R8 expected sample.
    function automatic int expect_sample();
        int a, b, m;
        a = wave_of(ph_a, wave_square);
        b = wave_of(ph_b, wave_square);
        m = dual_tone ? ((a >>> 1) + (b >>> 1)) : a;
        return (m * gain_of(int'(atten_code))) >>> 15;
    endfunction

    // R3 phase step.
    function automatic int incr_of(input int code);
        int sh;
        sh = (range_sel == 2'd0) ? 0 : (range_sel == 2'd1) ? 1 : 2;
        return code << sh;
    endfunction

    task automatic check(input string tag, input int act, input int exp_v);
        checks++;
        if (act != exp_v) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp_v);
        end
    endtask

    // Disable for a cycle, apply config, check idle outputs, re-enable.
    task automatic set_cfg(input int fa, input int fb, input int rng,
                           input bit sq, input bit dual, input int att);
        @(negedge clk);
        enable      = 1'b0;
        freq_a      = 8'(fa);
        freq_b      = 8'(fb);
        range_sel   = 2'(rng);
        wave_square = sq;
        dual_tone   = dual;
        atten_code  = 4'(att);
        @(negedge clk);
        check("R1 idle out", int'(tone_out), 0);
        check("R1 idle valid", int'(tone_valid), 0);
        enable = 1'b1;
        ph_a = 0;
        ph_b = 0;
    endtask

    // One strobe: check the produced sample, then the hold cycle.
    task automatic do_tick(input string tag);
        int e;
        e = expect_sample();
        sample_tick = 1'b1;
        @(negedge clk);
        sample_tick = 1'b0;
        check("R2 valid", int'(tone_valid), 1);
        check(tag, int'(tone_out), e);
        ph_a = (ph_a + incr_of(int'(freq_a))) & 2047;
        ph_b = (ph_b + incr_of(int'(freq_b))) & 2047;
        @(negedge clk);
        check("R2 valid drop", int'(tone_valid), 0);
        check("R2 hold", int'(tone_out), e);
        @(negedge clk);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks + 1);
            $finish;
        end
    end

    initial begin : main
        // R1: reset state, even with enable and strobe high.
        enable = 1'b1;
        sample_tick = 1'b1;
        repeat (3) @(negedge clk);
        check("R1 reset out", int'(tone_out), 0);
        check("R1 reset valid", int'(tone_valid), 0);
        sample_tick = 1'b0;
        enable = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;

        // R4: full sine period at the smallest step visits every table point.
        set_cfg(1, 0, 0, 1'b0, 1'b0, 0);
        @(negedge clk);
        for (int k = 0; k < 2048; k++) do_tick("R4 sine");

        // R3 R5 R6 R7 R8: every range, waveform, mix mode and attenuation code.
        for (int rng = 0; rng < 4; rng++)
            for (int sq = 0; sq < 2; sq++)
                for (int du = 0; du < 2; du++)
                    for (int at = 0; at < 16; at++) begin
                        set_cfg(37, 91, rng, sq[0], du[0], at);
                        @(negedge clk);
                        for (int k = 0; k < 12; k++) do_tick("R3/R5/R6/R7/R8 sweep");
                    end

        // R3: all frequency codes at the widest range, dual tone, sine.
        for (int c = 0; c < 256; c++) begin
            set_cfg(c, 255 - c, 2, 1'b0, 1'b1, 3);
            @(negedge clk);
            for (int k = 0; k < 6; k++) do_tick("R3 code sweep");
        end

        // R1: strobe and disable in the same cycle; strobe must be dropped.
        set_cfg(200, 50, 1, 1'b0, 1'b1, 0);
        @(negedge clk);
        for (int k = 0; k < 5; k++) do_tick("R2 pre-collision");
        sample_tick = 1'b1;
        enable = 1'b0;
        @(negedge clk);
        sample_tick = 1'b0;
        check("R1 collision out", int'(tone_out), 0);
        check("R1 collision valid", int'(tone_valid), 0);
        enable = 1'b1;
        ph_a = 0;
        ph_b = 0;
        @(negedge clk);
        do_tick("R1 restart phase 0");
        do_tick("R1 restart advance");

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule